// File: doc/BRIEF.md
# Twelve-Bit Symbol Correction Applier

This block sits between a Reed-Solomon decoder that works on 12-bit symbols and the byte-wide buffer RAM that holds one flash page. The decoder hands over up to four corrections at once, each a symbol position and a 12-bit error pattern. The block turns each correction into one or two byte-level XOR updates and carries them out as read-modify-write cycles on the RAM port. It stops at the first correction that cannot be applied, marks the page as uncorrectable, and reports how many corrections it applied.

The buffer holds 2048 data bytes at addresses 0 to 2047, followed by 64 spare bytes at addresses 2048 to 2111. Spare byte i is at address 2048 + i. The symbols are packed twelve bits at a time, starting with the most significant bit. Symbol 0 is a padding symbol whose top nibble lies outside the buffer. Because of this, an odd symbol begins on a byte boundary and an even symbol begins on a nibble boundary. Symbol 1365 straddles the last data byte and the first spare byte.

Top module: `rs12_err_applier`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `ram_rd_en` and `ram_wr_en` are low.
- R2: A `start` seen while idle captures `n_corr`, `corr_pos` and `corr_pat`, where slot k occupies bits [11k+10:11k] of `corr_pos` and bits [12k+11:12k] of `corr_pat`. A count above 4 is treated as 4. `busy` stays high until the done cycle, and `start` or input changes during that time have no effect.
- R3: An odd position p ≤ 1364 XORs address (3p-1)/2 with pattern[11:4], then XORs the next address with {pattern[3:0], 4'h0}.
- R4: An even position p with 2 ≤ p ≤ 1364 XORs address 3p/2-1 with {4'h0, pattern[11:8]}, then XORs address 3p/2 with pattern[7:0].
- R5: Position 0 XORs address 0 with pattern[7:0] when pattern ≤ 0xFF. A larger pattern makes the page uncorrectable.
- R6: Position 1365 XORs data byte 2047 with pattern[11:4] and spare byte 0 (address 2048) with {pattern[3:0], 4'h0}.
- R7: Positions 1366 to 1374 follow the odd and even rules of R3 and R4 and land in the spare area. No access ever goes above address 2061.
- R8: A position above 1374 makes the page uncorrectable.
- R9: Corrections are processed in slot order. After an uncorrectable entry, no further RAM write occurs for the page, and writes already made stay in place.
- R10: Each byte update is a read strobe in one cycle, then a write in the next cycle to the same address with the returned byte XOR the mask. Read and write are never strobed together, and a symbol's lower address is updated first.
- R11: `done` pulses for one cycle at the end of every page, including a page with zero corrections. `fail` and `applied` give the uncorrectable flag and the number of fully applied corrections, and they hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page with the presented corrections |
| n_corr | input | 3 | Number of valid correction slots |
| corr_pos | input | 44 | Four packed 11-bit symbol positions |
| corr_pat | input | 48 | Four packed 12-bit error patterns |
| busy | output | 1 | Page in progress |
| done | output | 1 | One-cycle end-of-page pulse |
| fail | output | 1 | Page marked uncorrectable |
| applied | output | 3 | Corrections applied to the page |
| ram_rd_en | output | 1 | Buffer read strobe |
| ram_wr_en | output | 1 | Buffer write strobe |
| ram_addr | output | 12 | Buffer byte address |
| ram_wdata | output | 8 | Buffer write data |
| ram_rdata | input | 8 | Buffer read data, one cycle after the strobe |

## Verification
The hardest case to reach is two corrections that touch the same byte. An odd symbol and the even symbol after it share one byte, so the second read-modify-write must see the result of the first. Directed pages place adjacent positions such as 1 and 2, or 1373 and 1374, in one list, and the random pages draw positions close together. A second hard case is an uncorrectable entry in the middle of a list with valid entries after it. Directed pages put an out-of-range or oversized padding entry between good ones and check that the buffer holds exactly the earlier updates.

// File: rtl/rs12_fix_pkg.sv
package rs12_fix_pkg;

  localparam int unsigned SYM_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } seq_state_t;

  // First byte a symbol touches: the stream offset of the symbol is 12p-4 bits.
  function automatic int unsigned sym_lead_byte(input int unsigned p);
    if (p == 0) return 0;
    return (3 * p - 1) >> 1;
  endfunction

  function automatic logic [7:0] sym_lead_mask(input logic odd, input logic pad,
                                               input logic [SYM_W-1:0] pat);
    if (pad) return pat[7:0];
    if (odd) return pat[11:4];
    return {4'h0, pat[11:8]};
  endfunction

  function automatic logic [7:0] sym_tail_mask(input logic odd, input logic [SYM_W-1:0] pat);
    if (odd) return {pat[3:0], 4'h0};
    return pat[7:0];
  endfunction

  function automatic logic sym_uncorrectable(input int unsigned p, input logic [SYM_W-1:0] pat,
                                             input int unsigned last_pos);
    return (p > last_pos) || ((p == 0) && (pat[11:8] != 4'h0));
  endfunction

endpackage

// File: rtl/rs12_corr_store.sv
module rs12_corr_store
  import rs12_fix_pkg::*;
#(
  parameter int unsigned MAX_CORR = 4,
  parameter int unsigned POS_W    = 11,
  parameter int unsigned CNT_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CNT_W-1:0]          n_req,
  input  logic [MAX_CORR*POS_W-1:0] pos_flat,
  input  logic [MAX_CORR*SYM_W-1:0] pat_flat,
  input  logic [CNT_W-1:0]          sel,
  output logic [CNT_W-1:0]          n_eff,
  output logic [POS_W-1:0]          cur_pos,
  output logic [SYM_W-1:0]          cur_pat
);
  localparam int unsigned IDX_W = (MAX_CORR > 1) ? $clog2(MAX_CORR) : 1;

  logic [POS_W-1:0] pos_q [MAX_CORR];
  logic [SYM_W-1:0] pat_q [MAX_CORR];
  logic [IDX_W-1:0] sel_safe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_eff <= '0;
      for (int k = 0; k < MAX_CORR; k++) begin
        pos_q[k] <= '0;
        pat_q[k] <= '0;
      end
    end else if (load) begin
      n_eff <= (n_req > CNT_W'(MAX_CORR)) ? CNT_W'(MAX_CORR) : n_req;
      for (int k = 0; k < MAX_CORR; k++) begin
        pos_q[k] <= pos_flat[k*POS_W +: POS_W];
        pat_q[k] <= pat_flat[k*SYM_W +: SYM_W];
      end
    end
  end

  assign sel_safe = (sel < CNT_W'(MAX_CORR)) ? IDX_W'(sel) : '0;
  assign cur_pos  = pos_q[sel_safe];
  assign cur_pat  = pat_q[sel_safe];

endmodule

// File: rtl/rs12_sym_mapper.sv
module rs12_sym_mapper
  import rs12_fix_pkg::*;
#(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LAST_POS = 1374
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [SYM_W-1:0]  pat,
  output logic              bad,
  output logic              two_bytes,
  output logic [ADDR_W-1:0] lead_addr,
  output logic [7:0]        lead_mask,
  output logic [7:0]        tail_mask
);
  logic pad;

  always_comb begin
    pad       = (pos == '0);
    bad       = sym_uncorrectable(32'(pos), pat, LAST_POS);
    two_bytes = !pad;
    lead_addr = ADDR_W'(sym_lead_byte(32'(pos)));
    lead_mask = sym_lead_mask(pos[0], pad, pat);
    tail_mask = sym_tail_mask(pos[0], pat);
  end

endmodule

// File: rtl/rs12_rmw_seq.sv
module rs12_rmw_seq
  import rs12_fix_pkg::*;
#(
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  n_eff,
  input  logic              bad,
  input  logic              two_bytes,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [7:0]        lead_mask,
  input  logic [7:0]        tail_mask,
  input  logic [7:0]        ram_rdata,
  output logic              load,
  output logic [CNT_W-1:0]  idx,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  applied,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              apply_evt,
  output logic              reject_evt
);
  seq_state_t state_q, state_d;
  logic byte_q;
  logic list_end;
  logic last_byte;

  assign list_end   = (idx == n_eff);
  assign last_byte  = byte_q || !two_bytes;
  assign load       = (state_q == ST_IDLE) && start;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign ram_rd_en  = (state_q == ST_READ);
  assign ram_wr_en  = (state_q == ST_WRITE);
  assign ram_addr   = (ram_rd_en || ram_wr_en) ? lead_addr + ADDR_W'(byte_q) : '0;
  assign ram_wdata  = ram_wr_en ? (ram_rdata ^ (byte_q ? tail_mask : lead_mask)) : '0;
  assign reject_evt = (state_q == ST_EVAL) && !list_end && bad;
  assign apply_evt  = ram_wr_en && last_byte;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_EVAL;
      ST_EVAL:  state_d = (list_end || bad) ? ST_DONE : ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_byte ? ST_EVAL : ST_READ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= 1'b0;
      idx     <= '0;
      fail    <= 1'b0;
      applied <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        idx     <= '0;
        fail    <= 1'b0;
        applied <= '0;
      end
      if (state_q == ST_EVAL) byte_q <= 1'b0;
      if (reject_evt) fail <= 1'b1;
      if (ram_wr_en) begin
        if (last_byte) begin
          idx     <= idx + 1'b1;
          applied <= applied + 1'b1;
        end else begin
          byte_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rs12_err_applier.sv
module rs12_err_applier
  import rs12_fix_pkg::*;
#(
  parameter int unsigned MAX_CORR    = 4,
  parameter int unsigned POS_W       = 11,
  parameter int unsigned LAST_POS    = 1374,
  parameter int unsigned DATA_BYTES  = 2048,
  parameter int unsigned SPARE_BYTES = 64,
  localparam int unsigned ADDR_W     = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int unsigned CNT_W      = $clog2(MAX_CORR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CNT_W-1:0]          n_corr,
  input  logic [MAX_CORR*POS_W-1:0] corr_pos,
  input  logic [MAX_CORR*SYM_W-1:0] corr_pat,
  output logic                      busy,
  output logic                      done,
  output logic                      fail,
  output logic [CNT_W-1:0]          applied,
  output logic                      ram_rd_en,
  output logic                      ram_wr_en,
  output logic [ADDR_W-1:0]         ram_addr,
  output logic [7:0]                ram_wdata,
  input  logic [7:0]                ram_rdata
);
  logic              load;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  n_eff;
  logic [POS_W-1:0]  cur_pos;
  logic [SYM_W-1:0]  cur_pat;
  logic              bad;
  logic              two_bytes;
  logic [ADDR_W-1:0] lead_addr;
  logic [7:0]        lead_mask;
  logic [7:0]        tail_mask;
  logic              apply_evt;
  logic              reject_evt;

  rs12_corr_store #(.MAX_CORR(MAX_CORR), .POS_W(POS_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .n_req(n_corr),
    .pos_flat(corr_pos), .pat_flat(corr_pat), .sel(idx),
    .n_eff(n_eff), .cur_pos(cur_pos), .cur_pat(cur_pat)
  );

  rs12_sym_mapper #(.POS_W(POS_W), .ADDR_W(ADDR_W), .LAST_POS(LAST_POS)) u_map (
    .pos(cur_pos), .pat(cur_pat), .bad(bad), .two_bytes(two_bytes),
    .lead_addr(lead_addr), .lead_mask(lead_mask), .tail_mask(tail_mask)
  );

  rs12_rmw_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .n_eff(n_eff), .bad(bad),
    .two_bytes(two_bytes), .lead_addr(lead_addr), .lead_mask(lead_mask),
    .tail_mask(tail_mask), .ram_rdata(ram_rdata), .load(load), .idx(idx),
    .busy(busy), .done(done), .fail(fail), .applied(applied),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .apply_evt(apply_evt), .reject_evt(reject_evt)
  );

endmodule

// File: rtl/rs12_err_applier_chk.sv
module rs12_err_applier_chk #(
  parameter int unsigned MAX_CORR = 4,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LAST_POS = 1374
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  applied,
  input logic              ram_rd_en,
  input logic              ram_wr_en,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              apply_evt,
  input logic              reject_evt
);
  localparam int unsigned MAX_ADDR = ((3 * LAST_POS - 1) / 2) + 1;

  a_r10_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_en && ram_wr_en));

  a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> ($past(ram_rd_en) && ram_addr == $past(ram_addr)));

  a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> ram_wr_en);

  a_r10_apply_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |-> (ram_wr_en && !reject_evt));

  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en || ram_wr_en) |-> (32'(ram_addr) <= MAX_ADDR));

  a_r9_reject_ends_page: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (done && !ram_wr_en && fail));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(applied) <= MAX_CORR));

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fail) && $stable(applied)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_rd_en && !ram_wr_en && !done));

endmodule

bind rs12_err_applier rs12_err_applier_chk #(
  .MAX_CORR(MAX_CORR), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LAST_POS(LAST_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .applied(applied), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
  .ram_addr(ram_addr), .apply_evt(apply_evt), .reject_evt(reject_evt)
);

// File: tb/rs12_err_applier_test.sv
`timescale 1ns/1ps
module rs12_err_applier_test;
  localparam int MAXC = 4;
  localparam int PW   = 11;
  localparam int LAST = 1374;
  localparam int BUFN = 2112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            start = 1'b0;
  logic [2:0]      n_corr = '0;
  logic [MAXC*PW-1:0] corr_pos = '0;
  logic [MAXC*12-1:0] corr_pat = '0;
  logic busy, done, fail;
  logic [2:0] applied;
  logic ram_rd_en, ram_wr_en;
  logic [11:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = 8'h00;

  rs12_err_applier uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_corr(n_corr),
    .corr_pos(corr_pos), .corr_pat(corr_pat), .busy(busy), .done(done),
    .fail(fail), .applied(applied), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  logic [7:0] mem     [BUFN];
  logic [7:0] ref_mem [BUFN];

  always @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
    if (ram_wr_en) mem[ram_addr] <= ram_wdata;
  end

  int compared = 0;
  int mismatched = 0;
  int q_addr[$];
  int q_mask[$];
  bit exp_pending = 0;
  bit exp_fail = 0;
  int exp_cnt = 0;
  string page_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Reference: lay the pattern bits on a bit stream, symbol p starting at bit 12p-4.
  task automatic model_page(input int n, input int p[4], input int pt[4]);
    int ne;
    ne = (n > MAXC) ? MAXC : n;
    exp_fail = 0;
    exp_cnt = 0;
    for (int i = 0; i < ne; i++) begin
      int first;
      int m[2];
      bit used[2];
      bit bad;
      bad = (p[i] > LAST);
      first = (12 * p[i] - 4 < 0) ? 0 : (12 * p[i] - 4) / 8;
      m[0] = 0; m[1] = 0; used[0] = 0; used[1] = 0;
      for (int j = 0; j < 12; j++) begin
        int g;
        int bitv;
        g = 12 * p[i] - 4 + j;
        bitv = (pt[i] >> (11 - j)) & 1;
        if (g < 0) begin
          if (bitv != 0) bad = 1;
        end else begin
          used[g / 8 - first] = 1;
          m[g / 8 - first] = m[g / 8 - first] | (bitv << (7 - g % 8));
        end
      end
      if (bad) begin
        exp_fail = 1;
        break;
      end
      for (int s = 0; s < 2; s++) begin
        if (used[s]) begin
          q_addr.push_back(first + s);
          q_mask.push_back(m[s]);
        end
      end
      exp_cnt++;
    end
  endtask

  // Per-clock comparison of the RAM port and the end-of-page report.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_rd_en && ram_wr_en) check(0, "R10", "read and write together", 1, 0);
      if (ram_rd_en) begin
        if (q_addr.size() == 0) check(0, "R9", "unexpected read", int'(ram_addr), -1);
        else check(int'(ram_addr) == q_addr[0], page_req, "read address",
                   int'(ram_addr), q_addr[0]);
      end
      if (ram_wr_en) begin
        if (q_addr.size() == 0) begin
          check(0, "R9", "unexpected write", int'(ram_addr), -1);
        end else begin
          int a;
          int mk;
          int e;
          a = q_addr.pop_front();
          mk = q_mask.pop_front();
          e = int'(ref_mem[a]) ^ mk;
          check(int'(ram_addr) == a, page_req, "write address", int'(ram_addr), a);
          check(int'(ram_wdata) == e, page_req, "write data R10", int'(ram_wdata), e);
          ref_mem[a] = 8'(e);
        end
      end
      if (done) begin
        check(exp_pending, "R11", "done without page", 1, 0);
        check(fail == exp_fail, "R11", "fail flag", int'(fail), int'(exp_fail));
        check(int'(applied) == exp_cnt, "R11", "applied count", int'(applied), exp_cnt);
        check(q_addr.size() == 0, "R9", "writes left at done", q_addr.size(), 0);
        exp_pending = 0;
      end
    end
  end

  task automatic run_page(input string tag, input int n, input int p[4], input int pt[4],
                          input bit intrude);
    int t;
    int bad_bytes;
    @(negedge clk);
    while (busy) @(negedge clk);
    for (int k = 0; k < MAXC; k++) begin
      corr_pos[k*PW +: PW] = PW'(p[k]);
      corr_pat[k*12 +: 12] = 12'(pt[k]);
    end
    n_corr = 3'(n);
    page_req = tag;
    model_page(n, p, pt);
    exp_pending = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      // R2: a start while busy, with new inputs, must change nothing
      @(negedge clk);
      for (int k = 0; k < MAXC; k++) begin
        corr_pos[k*PW +: PW] = PW'(5 + k);
        corr_pat[k*12 +: 12] = 12'hFFF;
      end
      n_corr = 3'd4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (exp_pending && t < 300) begin
      @(negedge clk);
      t++;
    end
    check(!exp_pending, tag, "done never seen", int'(exp_pending), 0);
    @(negedge clk);
    bad_bytes = 0;
    for (int i = 0; i < BUFN; i++) if (mem[i] !== ref_mem[i]) bad_bytes++;
    check(bad_bytes == 0, tag, "buffer image bytes differing", bad_bytes, 0);
    check(!busy && !done, "R11", "idle after page", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R11 watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < BUFN; i++) begin
      mem[i] = 8'($urandom_range(0, 255));
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !ram_rd_en && !ram_wr_en, "R1", "outputs in reset",
          {busy, done, ram_rd_en, ram_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !ram_rd_en && !ram_wr_en, "R1", "outputs after reset",
          {busy, done, ram_rd_en, ram_wr_en}, 0);

    run_page("R11", 0, '{1, 2, 3, 4}, '{1, 1, 1, 1}, 0);
    run_page("R3", 1, '{1, 0, 0, 0}, '{12'hABC, 0, 0, 0}, 0);
    run_page("R3", 1, '{1363, 0, 0, 0}, '{12'h5E7, 0, 0, 0}, 0);
    run_page("R4", 1, '{2, 0, 0, 0}, '{12'h9D3, 0, 0, 0}, 0);
    run_page("R4", 1, '{1364, 0, 0, 0}, '{12'h2C1, 0, 0, 0}, 0);
    run_page("R5", 1, '{0, 0, 0, 0}, '{12'h05A, 0, 0, 0}, 0);
    run_page("R5", 2, '{0, 7, 0, 0}, '{12'h1A5, 12'h333, 0, 0}, 0);
    run_page("R6", 1, '{1365, 0, 0, 0}, '{12'hF3C, 0, 0, 0}, 0);
    run_page("R7", 4, '{1366, 1373, 1374, 1370}, '{12'h123, 12'h456, 12'h789, 12'hFED}, 0);
    run_page("R8", 1, '{1375, 0, 0, 0}, '{12'h001, 0, 0, 0}, 0);
    run_page("R9", 3, '{10, 1375, 20, 0}, '{12'h777, 12'h111, 12'h222, 0}, 0);
    run_page("R9", 4, '{30, 31, 0, 40}, '{12'h0F0, 12'h00F, 12'h300, 12'h444}, 0);
    run_page("R10", 4, '{1, 2, 2, 1}, '{12'hFFF, 12'h800, 12'h0F1, 12'h011}, 0);
    run_page("R2", 7, '{100, 101, 102, 103}, '{12'h111, 12'h222, 12'h333, 12'h444}, 0);
    run_page("R2", 4, '{200, 201, 202, 203}, '{12'hA5A, 12'h5A5, 12'hC3C, 12'h3C3}, 1);

    for (int r = 0; r < 40; r++) begin
      int p[4];
      int pt[4];
      int base;
      base = $urandom_range(0, 1376);
      for (int k = 0; k < 4; k++) begin
        p[k] = ($urandom_range(0, 3) == 0) ? base + $urandom_range(0, 3)
                                            : $urandom_range(0, 1378);
        pt[k] = (p[k] == 0) ? $urandom_range(0, 300) : $urandom_range(1, 4095);
      end
      run_page("R10", $urandom_range(0, 5), p, pt, 0);
    end

    report();
    $finish;
  end

endmodule